// File: doc/BRIEF.md
# Local Lock Assist Sequencer

This block carries out, in hardware, the obtain or release of the local lock that belongs to one address space. A single strobe starts it. It then walks a fixed series of single-word accesses on a 32-bit memory port. First it gathers the address-space control-block pointer, the word of held-lock flags and the logical address of this CPU. Then it fetches the lock word and, for a release, the suspend-queue word. From these it decides whether the operation can go ahead.

On success it updates shared memory with three writes in a fixed order and reports a zero result for register 13. On failure it performs no writes. Instead it reads a table base from memory, steps back to the error entry for the operation, and reports a branch: the old instruction address goes to register 12, and the new one goes to register 13 and to the branch target.

A privilege check and an alignment check run before any memory access. A lock output stays high for the whole access series, so that no other requester can slip an access in between. Results are registered and come out with a one-cycle done pulse.

Top module: `lock_assist_seq`

## Requirements
- R1: When `start` is sampled with `priv_ok` low, the block pulses `done` with `priv_exc` high and `spec_exc` low on the next cycle. This holds even if the operands are misaligned. No memory request is made and no register write is flagged.
- R2: When `start` is sampled with `priv_ok` high and bits [1:0] of either operand address nonzero, the block pulses `done` with `spec_exc` high on the next cycle. No memory request is made.
- R3: The reads are issued in this order, with every derived address ANDed with `wrap_mask`:
  - operand 1, which yields the control-block pointer P;
  - operand 2, which yields the held-lock word H;
  - operand 2 minus 4, which yields the CPU address C;
  - P+0x80, which yields the lock word L;
  - for a release only, P+0x84, which yields the suspend word S.
- R4: An obtain succeeds exactly when L is zero and bit 0 of H (local lock held) is clear. Bit 1 of H (shared lock held) does not matter.
- R5: A successful obtain issues three writes in this order: H to operand 2, then C to P+0x80, then H with bit 0 set to operand 2. It then finishes with `r13_we` high, `r13_val` zero and `r12_we` low.
- R6: A release succeeds exactly when L equals C, bits [1:0] of H equal 2'b01, and S is zero.
- R7: A successful release issues three writes in this order: H to operand 2, then zero to P+0x80, then H with bit 0 cleared to operand 2. It then finishes with `r13_we` high and `r13_val` zero.
- R8: On failure no write is issued. The block reads the table base T from operand 2 plus 4. It then reads the new address N at (T−16) for an obtain or (T−12) for a release, masked with `wrap_mask`. It finishes with `branch_taken` high, `r12_val` equal to `cur_ia`, and both `r13_val` and `new_ia` equal to N.
- R9: `mem_lock` rises on the cycle after an accepted operation starts and stays high through the acknowledge of the last access, including the gaps between accesses. It is low whenever `done` is high or the block is idle, and `mem_req` is never high without it.
- R10: At most one request is outstanding at a time. While `mem_req` is high without `mem_ack`, the request's address, write flag and write data stay unchanged.
- R11: A `start` that arrives while an operation is running is ignored, together with its operand, select and privilege inputs. Operand values are captured when an operation is accepted.
- R12: `done` is a one-cycle pulse. `spec_exc`, `priv_exc`, `branch_taken`, `r12_we` and `r13_we` are high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| op_release | input | 1 | 0 = obtain, 1 = release |
| opnd1_addr | input | W | Address of the control-block pointer word |
| opnd2_addr | input | W | Address of the held-lock word |
| cur_ia | input | W | Current instruction address, reported as link |
| wrap_mask | input | W | AND mask applied to derived addresses |
| priv_ok | input | 1 | Issuer is in privileged state |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | W | Request word address (byte address) |
| mem_wdata | output | W | Write data |
| mem_ack | input | 1 | Request accepted this cycle; read data valid |
| mem_rdata | input | W | Read data |
| mem_lock | output | 1 | Exclusive hold on the memory path |
| done | output | 1 | Operation finished (one cycle) |
| spec_exc | output | 1 | Operand alignment exception |
| priv_exc | output | 1 | Privileged-operation exception |
| r12_we | output | 1 | Register 12 write enable |
| r12_val | output | W | Value for register 12 |
| r13_we | output | 1 | Register 13 write enable |
| r13_val | output | W | Value for register 13 |
| branch_taken | output | 1 | Failure branch taken |
| new_ia | output | W | Branch target address |

## Verification
The bench builds the block with its defaults: a 32-bit word, a lock offset of 0x80, a suspend offset of 0x84, and table offsets of −16 and −12. It drives a wrap mask of 0x3FF, so a 256-word array covers the whole address space the block can reach. This lets a control-block pointer near the top of that space wrap the lock address down to 0x020, and a zero table base wrap the error entry to 0x3F0 and 0x3F4. The memory acknowledge latency rotates through zero, one and two wait cycles, which exercises the hold-until-acknowledge rule and the lock gaps between accesses.

// File: rtl/lla_pkg.sv
package lla_pkg;
  // Bit positions inside the held-lock word
  localparam int LOCAL_HELD_BIT  = 0;
  localparam int SHARED_HELD_BIT = 1;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_CB,
    S_RD_HELD,
    S_RD_CPU,
    S_RD_LOCK,
    S_RD_SUSP,
    S_WR_HELD0,
    S_WR_LOCK,
    S_WR_HELD1,
    S_RD_TBL,
    S_RD_NIA
  } seq_state_t;
endpackage

// File: rtl/lla_addr_gen.sv
module lla_addr_gen
  import lla_pkg::*;
#(
  parameter int W        = 32,
  parameter int LOCK_OFS = 128,
  parameter int SUSP_OFS = 132,
  parameter int OBT_OFS  = -16,
  parameter int REL_OFS  = -12
) (
  input  seq_state_t     cur,
  input  logic           rel,
  input  logic [W-1:0]   op1,
  input  logic [W-1:0]   op2,
  input  logic [W-1:0]   mask,
  input  logic [W-1:0]   cb,
  input  logic [W-1:0]   cpu,
  input  logic [W-1:0]   held,
  input  logic [W-1:0]   tbl,
  output logic [W-1:0]   addr,
  output logic           we,
  output logic [W-1:0]   wdata
);
  localparam logic [W-1:0] LOCK_W = W'(LOCK_OFS);
  localparam logic [W-1:0] SUSP_W = W'(SUSP_OFS);
  localparam logic [W-1:0] OBT_W  = W'(OBT_OFS);
  localparam logic [W-1:0] REL_W  = W'(REL_OFS);
  localparam logic [W-1:0] STEP_W = W'(4);
  localparam logic [W-1:0] LBIT_W = W'(1) << LOCAL_HELD_BIT;

  logic [W-1:0] lock_loc;
  logic [W-1:0] entry_ofs;

  assign lock_loc  = (cb + LOCK_W) & mask;
  assign entry_ofs = rel ? REL_W : OBT_W;

  always_comb begin
    addr  = '0;
    we    = 1'b0;
    wdata = '0;
    case (cur)
      S_RD_CB:    addr = op1;
      S_RD_HELD:  addr = op2;
      S_RD_CPU:   addr = (op2 - STEP_W) & mask;
      S_RD_LOCK:  addr = lock_loc;
      S_RD_SUSP:  addr = (cb + SUSP_W) & mask;
      S_WR_HELD0: begin
        addr  = op2;
        we    = 1'b1;
        wdata = held;
      end
      S_WR_LOCK: begin
        addr  = lock_loc;
        we    = 1'b1;
        wdata = rel ? '0 : cpu;
      end
      S_WR_HELD1: begin
        addr  = op2;
        we    = 1'b1;
        wdata = rel ? (held & ~LBIT_W) : (held | LBIT_W);
      end
      S_RD_TBL:   addr = (op2 + STEP_W) & mask;
      S_RD_NIA:   addr = (tbl + entry_ofs) & mask;
      default:    addr = '0;
    endcase
  end
endmodule

// File: rtl/lla_verdict.sv
module lla_verdict
  import lla_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         rel,
  input  logic [1:0]   held_lo,
  input  logic [W-1:0] cpu,
  input  logic [W-1:0] lock,
  input  logic [W-1:0] susp,
  output logic         ok
);
  logic obtain_ok;
  logic release_ok;

  assign obtain_ok  = (lock == '0) && !held_lo[LOCAL_HELD_BIT];
  assign release_ok = (lock == cpu) && held_lo[LOCAL_HELD_BIT] &&
                      !held_lo[SHARED_HELD_BIT] && (susp == '0);
  assign ok = rel ? release_ok : obtain_ok;
endmodule

// File: rtl/lock_assist_seq.sv
module lock_assist_seq
  import lla_pkg::*;
#(
  parameter int W        = 32,
  parameter int LOCK_OFS = 128,
  parameter int SUSP_OFS = 132,
  parameter int OBT_OFS  = -16,
  parameter int REL_OFS  = -12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         op_release,
  input  logic [W-1:0] opnd1_addr,
  input  logic [W-1:0] opnd2_addr,
  input  logic [W-1:0] cur_ia,
  input  logic [W-1:0] wrap_mask,
  input  logic         priv_ok,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic         mem_ack,
  input  logic [W-1:0] mem_rdata,
  output logic         mem_lock,
  output logic         done,
  output logic         spec_exc,
  output logic         priv_exc,
  output logic         r12_we,
  output logic [W-1:0] r12_val,
  output logic         r13_we,
  output logic [W-1:0] r13_val,
  output logic         branch_taken,
  output logic [W-1:0] new_ia
);
  localparam int ALIGN_BITS = 2;

  seq_state_t   state, nxt;
  logic [W-1:0] op1_q, op2_q, ia_q, mask_q;
  logic         rel_q;
  logic [W-1:0] cb_q, held_q, cpu_q, lock_q, tbl_q;
  logic [W-1:0] ag_addr, ag_wdata;
  logic         ag_we;
  logic [W-1:0] lock_in;
  logic         grant_ok;
  logic         misalign;
  logic         acked;
  logic         accept;

  assign misalign = (|opnd1_addr[ALIGN_BITS-1:0]) | (|opnd2_addr[ALIGN_BITS-1:0]);
  assign acked    = mem_req & mem_ack;
  assign accept   = (state == S_IDLE) & start;
  assign lock_in  = (state == S_RD_LOCK) ? mem_rdata : lock_q;

  lla_addr_gen #(
    .W(W), .LOCK_OFS(LOCK_OFS), .SUSP_OFS(SUSP_OFS),
    .OBT_OFS(OBT_OFS), .REL_OFS(REL_OFS)
  ) u_ag (
    .cur(state), .rel(rel_q), .op1(op1_q), .op2(op2_q), .mask(mask_q),
    .cb(cb_q), .cpu(cpu_q), .held(held_q), .tbl(tbl_q),
    .addr(ag_addr), .we(ag_we), .wdata(ag_wdata)
  );

  lla_verdict #(.W(W)) u_vd (
    .rel(rel_q), .held_lo(held_q[1:0]), .cpu(cpu_q),
    .lock(lock_in), .susp(mem_rdata), .ok(grant_ok)
  );

  // Next-state decision; every memory state advances only on acknowledge
  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:     if (start && priv_ok && !misalign) nxt = S_RD_CB;
      S_RD_CB:    if (acked) nxt = S_RD_HELD;
      S_RD_HELD:  if (acked) nxt = S_RD_CPU;
      S_RD_CPU:   if (acked) nxt = S_RD_LOCK;
      S_RD_LOCK:  if (acked) nxt = rel_q ? S_RD_SUSP :
                                   (grant_ok ? S_WR_HELD0 : S_RD_TBL);
      S_RD_SUSP:  if (acked) nxt = grant_ok ? S_WR_HELD0 : S_RD_TBL;
      S_WR_HELD0: if (acked) nxt = S_WR_LOCK;
      S_WR_LOCK:  if (acked) nxt = S_WR_HELD1;
      S_WR_HELD1: if (acked) nxt = S_IDLE;
      S_RD_TBL:   if (acked) nxt = S_RD_NIA;
      S_RD_NIA:   if (acked) nxt = S_IDLE;
      default:    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      op1_q        <= '0;
      op2_q        <= '0;
      ia_q         <= '0;
      mask_q       <= '0;
      rel_q        <= 1'b0;
      cb_q         <= '0;
      held_q       <= '0;
      cpu_q        <= '0;
      lock_q       <= '0;
      tbl_q        <= '0;
      mem_req      <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      mem_lock     <= 1'b0;
      done         <= 1'b0;
      spec_exc     <= 1'b0;
      priv_exc     <= 1'b0;
      r12_we       <= 1'b0;
      r12_val      <= '0;
      r13_we       <= 1'b0;
      r13_val      <= '0;
      branch_taken <= 1'b0;
      new_ia       <= '0;
    end else begin
      state        <= nxt;
      done         <= 1'b0;
      spec_exc     <= 1'b0;
      priv_exc     <= 1'b0;
      r12_we       <= 1'b0;
      r13_we       <= 1'b0;
      branch_taken <= 1'b0;

      // Accept: capture operands, screen privilege then alignment
      if (accept) begin
        op1_q  <= opnd1_addr;
        op2_q  <= opnd2_addr;
        ia_q   <= cur_ia;
        mask_q <= wrap_mask;
        rel_q  <= op_release;
        if (!priv_ok) begin
          done     <= 1'b1;
          priv_exc <= 1'b1;
        end else if (misalign) begin
          done     <= 1'b1;
          spec_exc <= 1'b1;
        end else begin
          mem_lock <= 1'b1;
        end
      end

      // Request issue: one access per state, held until acknowledged
      if (state != S_IDLE) begin
        if (!mem_req) begin
          mem_req   <= 1'b1;
          mem_addr  <= ag_addr;
          mem_we    <= ag_we;
          mem_wdata <= ag_wdata;
        end else if (mem_ack) begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
        end
      end

      // Read data capture
      if (acked) begin
        case (state)
          S_RD_CB:   cb_q   <= mem_rdata;
          S_RD_HELD: held_q <= mem_rdata;
          S_RD_CPU:  cpu_q  <= mem_rdata;
          S_RD_LOCK: lock_q <= mem_rdata;
          S_RD_TBL:  tbl_q  <= mem_rdata;
          default:   ;
        endcase
      end

      // Completion
      if (acked && state == S_WR_HELD1) begin
        done     <= 1'b1;
        r13_we   <= 1'b1;
        r13_val  <= '0;
        mem_lock <= 1'b0;
      end
      if (acked && state == S_RD_NIA) begin
        done         <= 1'b1;
        r12_we       <= 1'b1;
        r12_val      <= ia_q;
        r13_we       <= 1'b1;
        r13_val      <= mem_rdata;
        branch_taken <= 1'b1;
        new_ia       <= mem_rdata;
        mem_lock     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lla_checker.sv
module lla_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         mem_req,
  input logic         mem_ack,
  input logic         mem_we,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic         mem_lock,
  input logic         done,
  input logic         spec_exc,
  input logic         priv_exc,
  input logic         r12_we,
  input logic         r13_we,
  input logic [W-1:0] r13_val,
  input logic [W-1:0] new_ia,
  input logic         branch_taken
);
  AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_lock); // R9

  AST_DONE_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_lock && !mem_req)); // R9

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata))); // R10

  AST_EXC_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (priv_exc || spec_exc) |-> (!$past(mem_lock) && !$past(mem_req))); // R2

  AST_PRIV_FIRST: assert property (@(posedge clk) disable iff (rst)
    priv_exc |-> (!spec_exc && !r12_we && !r13_we)); // R1

  AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    (spec_exc || priv_exc || branch_taken || r12_we || r13_we) |-> done); // R12

  AST_EXC_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({spec_exc, priv_exc, branch_taken})); // R12

  AST_BRANCH_REGS: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> (r12_we && r13_we && r13_val == new_ia)); // R8

  AST_SUCCESS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (r13_we && !r12_we) |-> (r13_val == '0)); // R5
endmodule

bind lock_assist_seq lla_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_lock(mem_lock), .done(done),
  .spec_exc(spec_exc), .priv_exc(priv_exc), .r12_we(r12_we), .r13_we(r13_we),
  .r13_val(r13_val), .new_ia(new_ia), .branch_taken(branch_taken)
);

// File: tb/sim_lock_assist_seq.sv
module sim_lock_assist_seq;
  localparam int W = 32;
  localparam int DEPTH = 256;
  localparam logic [31:0] MASK = 32'h0000_03FF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, op_release = 1'b0, priv_ok = 1'b1;
  logic [W-1:0] opnd1_addr = '0, opnd2_addr = '0, cur_ia = '0, wrap_mask = MASK;
  logic mem_req, mem_we, mem_lock, done, spec_exc, priv_exc;
  logic r12_we, r13_we, branch_taken;
  logic [W-1:0] mem_addr, mem_wdata, r12_val, r13_val, new_ia;
  logic mem_ack = 1'b0;
  logic [W-1:0] mem_rdata = '0;

  always #5 clk = ~clk;

  lock_assist_seq u0 (
    .clk(clk), .rst(rst), .start(start), .op_release(op_release),
    .opnd1_addr(opnd1_addr), .opnd2_addr(opnd2_addr), .cur_ia(cur_ia),
    .wrap_mask(wrap_mask), .priv_ok(priv_ok),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_lock(mem_lock),
    .done(done), .spec_exc(spec_exc), .priv_exc(priv_exc),
    .r12_we(r12_we), .r12_val(r12_val), .r13_we(r13_we), .r13_val(r13_val),
    .branch_taken(branch_taken), .new_ia(new_ia)
  );

  logic [31:0] mem [DEPTH];
  int checks = 0;
  int fails = 0;
  bit running = 1'b0;
  int lat = 0, lat_seq = 0, wcnt = 0;
  logic [31:0] pend_addr;

  bit          exp_we_q[$];
  logic [31:0] exp_addr_q[$];
  logic [31:0] exp_data_q[$];
  string       exp_tag_q[$];

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem[a[9:2]];
  endfunction

  task automatic bad(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    fails++;
    $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) bad(req, what, act, exp);
  endtask

  task automatic push(input bit we, input logic [31:0] a, input logic [31:0] d,
                      input string tag);
    exp_we_q.push_back(we);
    exp_addr_q.push_back(a);
    exp_data_q.push_back(d);
    exp_tag_q.push_back(tag);
  endtask

  // Memory model and per-clock protocol comparison
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end
    if (!rst) begin
      checks++;
      if (mem_req && !mem_lock) bad("R9", "req without lock", 32'(mem_lock), 32'd1);
      if (!running && mem_lock) bad("R9", "lock while idle", 32'(mem_lock), 32'd0);
    end
    if (!rst && mem_req) begin
      if (wcnt == 0) pend_addr = mem_addr;
      else if (mem_addr !== pend_addr) bad("R10", "addr moved while waiting", mem_addr, pend_addr);
      if (wcnt >= lat) begin
        checks++;
        if (exp_addr_q.size() == 0) begin
          bad("R3", "unexpected access", mem_addr, 32'hFFFF_FFFF);
        end else begin
          automatic bit          ew = exp_we_q.pop_front();
          automatic logic [31:0] ea = exp_addr_q.pop_front();
          automatic logic [31:0] ed = exp_data_q.pop_front();
          automatic string       et = exp_tag_q.pop_front();
          if (mem_we !== ew) bad(et, "access kind", 32'(mem_we), 32'(ew));
          if (mem_addr !== ea) bad(et, "access addr", mem_addr, ea);
          if (ew && mem_wdata !== ed) bad(et, "write data", mem_wdata, ed);
        end
        if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
        else mem_rdata = mem[mem_addr[9:2]];
        mem_ack = 1'b1;
        lat_seq++;
        lat = lat_seq % 3;
      end else begin
        wcnt++;
      end
    end
  end

  // Behavioural reference for one operation, then drive and compare
  task automatic run_op(input bit rel, input logic [31:0] o1, input logic [31:0] o2,
                        input logic [31:0] ia, input bit priv, input bit poke,
                        input string tag);
    bit e_priv, e_spec, e_br, e_ok;
    logic [31:0] cb, held, cpu, la, lk, sa, sp, tb, ta, nia;
    int n;
    e_priv = 0; e_spec = 0; e_br = 0; e_ok = 0; nia = 0;
    if (!priv) e_priv = 1;
    else if (o1[1:0] != 0 || o2[1:0] != 0) e_spec = 1;
    else begin
      cb = rd(o1); held = rd(o2); cpu = rd((o2 - 4) & MASK);
      la = (cb + 32'h80) & MASK; lk = rd(la);
      push(0, o1, 0, "R3"); push(0, o2, 0, "R3");
      push(0, (o2 - 4) & MASK, 0, "R3"); push(0, la, 0, "R3");
      sp = 0;
      if (rel) begin
        sa = (cb + 32'h84) & MASK; sp = rd(sa);
        push(0, sa, 0, "R3");
        e_ok = (lk == cpu) && (held[1:0] == 2'b01) && (sp == 0);
      end else begin
        e_ok = (lk == 0) && !held[0];
      end
      if (e_ok) begin
        push(1, o2, held, rel ? "R7" : "R5");
        push(1, la, rel ? 32'h0 : cpu, rel ? "R7" : "R5");
        push(1, o2, rel ? (held & ~32'h1) : (held | 32'h1), rel ? "R7" : "R5");
      end else begin
        e_br = 1;
        tb = rd((o2 + 4) & MASK);
        ta = (tb + (rel ? 32'hFFFF_FFF4 : 32'hFFFF_FFF0)) & MASK;
        nia = rd(ta);
        push(0, (o2 + 4) & MASK, 0, "R8"); push(0, ta, 0, "R8");
      end
    end

    @(negedge clk);
    start = 1; op_release = rel; opnd1_addr = o1; opnd2_addr = o2;
    cur_ia = ia; priv_ok = priv; running = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      @(negedge clk);
      start = 1; op_release = ~rel; priv_ok = 0;
      opnd1_addr = 32'h3; opnd2_addr = 32'h3; cur_ia = 32'hDEAD;
      @(negedge clk);
      start = 0; priv_ok = 1;
    end
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk("R12", {tag, " done seen"}, 32'(done), 32'd1);
    chk("R1", {tag, " priv_exc"}, 32'(priv_exc), 32'(e_priv));
    chk("R2", {tag, " spec_exc"}, 32'(spec_exc), 32'(e_spec));
    chk("R8", {tag, " branch"}, 32'(branch_taken), 32'(e_br));
    chk("R8", {tag, " r12_we"}, 32'(r12_we), 32'(e_br));
    chk(rel ? "R7" : "R5", {tag, " r13_we"}, 32'(r13_we), 32'(!e_priv && !e_spec));
    if (e_ok) chk(rel ? "R7" : "R5", {tag, " r13 zero"}, r13_val, 32'h0);
    if (e_br) begin
      chk("R8", {tag, " r12 link"}, r12_val, ia);
      chk("R8", {tag, " r13 target"}, r13_val, nia);
      chk("R8", {tag, " new_ia"}, new_ia, nia);
    end
    chk("R9", {tag, " lock low at done"}, 32'(mem_lock), 32'd0);
    chk(e_ok ? (rel ? "R7" : "R5") : "R3", {tag, " accesses left"},
        32'(exp_addr_q.size()), 32'd0);
    exp_we_q.delete(); exp_addr_q.delete(); exp_data_q.delete(); exp_tag_q.delete();
    running = 0;
    @(negedge clk);
    chk("R12", {tag, " done one cycle"}, 32'(done), 32'd0);
    repeat (3) begin
      @(negedge clk);
      chk(poke ? "R11" : "R12", {tag, " no extra done"}, 32'(done | mem_req), 32'd0);
    end
  endtask

  initial begin
    #1_000_000;
    bad("WATCHDOG", "run timed out", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 32'h0;
    mem[32'h100 >> 2] = 32'h300;    // control-block pointer
    mem[32'h200 >> 2] = 32'hC2;     // CPU address
    mem[32'h204 >> 2] = 32'h0;      // held-lock word
    mem[32'h208 >> 2] = 32'h140;    // table base
    mem[32'h130 >> 2] = 32'h5000;   // obtain error entry
    mem[32'h134 >> 2] = 32'h6000;   // release error entry
    mem[32'h110 >> 2] = 32'h3A0;    // pointer near the top of the space
    mem[32'h3F0 >> 2] = 32'h7770;   // wrapped obtain entry
    mem[32'h3F4 >> 2] = 32'h7774;   // wrapped release entry

    repeat (3) @(negedge clk);
    chk("R12", "reset done", 32'(done), 32'd0);
    chk("R9", "reset req", 32'(mem_req), 32'd0);
    chk("R9", "reset lock", 32'(mem_lock), 32'd0);
    rst = 0;
    @(negedge clk);

    run_op(0, 32'h100, 32'h204, 32'h1000, 1, 0, "R4 obtain free");
    run_op(0, 32'h100, 32'h204, 32'h1004, 1, 0, "R8 obtain busy");
    run_op(1, 32'h100, 32'h204, 32'h1008, 1, 0, "R6 release ok");
    mem[32'h380 >> 2] = 32'h77;
    run_op(0, 32'h100, 32'h204, 32'h100C, 1, 0, "R4 lock taken");
    mem[32'h380 >> 2] = 32'h0;
    mem[32'h204 >> 2] = 32'h2;
    run_op(0, 32'h100, 32'h204, 32'h1010, 1, 0, "R4 shared only");
    run_op(1, 32'h100, 32'h204, 32'h1014, 1, 0, "R6 shared held");
    mem[32'h204 >> 2] = 32'h1;
    mem[32'h384 >> 2] = 32'h55;
    run_op(1, 32'h100, 32'h204, 32'h1018, 1, 0, "R6 queue busy");
    mem[32'h384 >> 2] = 32'h0;
    mem[32'h380 >> 2] = 32'h99;
    run_op(1, 32'h100, 32'h204, 32'h101C, 1, 0, "R6 other owner");
    mem[32'h380 >> 2] = 32'hC2;
    run_op(1, 32'h100, 32'h204, 32'h1020, 1, 0, "R7 release");
    run_op(0, 32'h102, 32'h206, 32'h1024, 0, 0, "R1 priv first");
    run_op(0, 32'h102, 32'h204, 32'h1028, 1, 0, "R2 op1 odd");
    run_op(1, 32'h100, 32'h206, 32'h102C, 1, 0, "R2 op2 odd");
    mem[32'h020 >> 2] = 32'h1;
    mem[32'h208 >> 2] = 32'h0;
    run_op(0, 32'h110, 32'h204, 32'h1030, 1, 0, "R3 wrap fail");
    run_op(1, 32'h110, 32'h204, 32'h1034, 1, 0, "R8 wrap release");
    mem[32'h020 >> 2] = 32'h0;
    run_op(0, 32'h110, 32'h204, 32'h1038, 1, 0, "R3 wrap obtain");
    run_op(1, 32'h110, 32'h204, 32'h103C, 1, 1, "R11 busy start");
    chk("R7", "lock word cleared", mem[32'h020 >> 2], 32'h0);
    chk("R7", "held bit cleared", mem[32'h204 >> 2], 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule